// File: doc/BRIEF.md
# Audio Frame Sequencer

The frame sequencer turns a slow step enable, one pulse per sequencer step, into the periodic housekeeping strobes of a set of tone channels. Every step produces a quarter-frame strobe, which clocks envelopes and the linear counter. Some steps also produce a half-frame strobe, which clocks length counters and sweep units. The sequencer runs either a four-step or a five-step schedule. In the four-step schedule it can also raise a frame interrupt.

A mode write loads the schedule select and restarts the sequence at step 0. The interrupt is a stored, level-sensitive flag. It stays high until the host acknowledges it. Holding the inhibit input high clears the flag and keeps it clear. All outputs are registered. The strobes for a step appear in the cycle after the clock edge that sampled the step enable, and each lasts one cycle.

Top module: `frame_sequencer`

## Requirements
- R1: During and after reset, `qtr_tick`, `half_tick` and `frame_irq` are 0, the schedule is four-step and the next step taken is step 0.
- R2: In four-step mode (`mode_sel` = 0) the steps run 0,1,2,3 and then wrap to 0. Every step gives a quarter-frame strobe, and steps 0 and 2 also give a half-frame strobe.
- R3: In four-step mode, taking step 0 while `irq_inhibit` is low sets the frame interrupt flag. No other step sets it, and no step sets it in five-step mode.
- R4: In five-step mode (`mode_sel` = 1) the steps run 0,1,2,3,4 and then wrap to 0. Every step gives a quarter-frame strobe, steps 0 and 2 also give a half-frame strobe, and step 4 gives a quarter-frame strobe only.
- R5: The strobes of a step are high for exactly the one cycle after the edge that sampled `step_en`. Without a step the strobes stay 0.
- R6: Once set, `frame_irq` stays high until an edge samples `irq_ack` high, after which it reads 0.
- R7: While `irq_inhibit` is sampled high, `frame_irq` is 0 in the next cycle, whatever step or acknowledge comes in the same cycle.
- R8: An edge that samples `mode_wr` high loads `mode_sel` as the schedule and makes the next step taken step 0. A `step_en` in that same cycle is dropped and produces no strobe.
- R9: When a flag-setting step 0 and `irq_ack` are sampled at the same edge with `irq_inhibit` low, the flag is set afterwards: the set takes priority over the acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | One-cycle pulse that advances the sequence by one step |
| mode_wr | input | 1 | Mode write strobe: loads mode_sel and restarts at step 0 |
| mode_sel | input | 1 | Schedule select: 0 = four-step, 1 = five-step |
| irq_inhibit | input | 1 | Level input that blocks and clears the frame interrupt |
| irq_ack | input | 1 | Pulse that clears the frame interrupt flag |
| qtr_tick | output | 1 | Quarter-frame strobe |
| half_tick | output | 1 | Half-frame strobe |
| frame_irq | output | 1 | Stored frame interrupt flag |

## Verification
Two actions on the flag can meet in one cycle. One is a step 0 in four-step mode, which sets the flag. The other is an acknowledge or an inhibit, which clears it. The bench aligns `irq_ack` with a step 0 and expects the flag to be high afterwards. It then aligns `irq_inhibit` with a step 0 and expects it to be low. A mode write that lands on a step is also provoked: the step must vanish and the sequence must restart at step 0. The behavioural model judges every cycle of these cases and of a long stretch of random stimulus.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  // schedule lengths
  localparam int unsigned SHORT_LEN = 4;
  localparam int unsigned LONG_LEN  = 5;
  localparam int unsigned IDX_W     = $clog2(LONG_LEN);

  typedef logic [IDX_W-1:0] step_idx_t;

  // last index of the active schedule
  function automatic step_idx_t last_index(input logic five);
    return five ? step_idx_t'(LONG_LEN - 1) : step_idx_t'(SHORT_LEN - 1);
  endfunction

  // index following idx, wrapping at the end of the schedule
  function automatic step_idx_t next_index(input logic five, input step_idx_t idx);
    return (idx == last_index(five)) ? '0 : step_idx_t'(idx + 1'b1);
  endfunction

  // half-frame steps are the same in both schedules
  function automatic logic step_half(input step_idx_t idx);
    return (idx == step_idx_t'(0)) || (idx == step_idx_t'(2));
  endfunction

  // only step 0 of the four-step schedule raises the interrupt
  function automatic logic step_raises_irq(input logic five, input step_idx_t idx);
    return !five && (idx == step_idx_t'(0));
  endfunction

endpackage

// File: rtl/fseq_stepper.sv
module fseq_stepper
  import fseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step_en,
  input  logic      mode_wr,
  input  logic      mode_sel,
  output step_idx_t cur_idx,
  output logic      five_mode,
  output logic      step_fire
);

  step_idx_t idx_q;
  logic      five_q;

  // a mode write swallows a coincident step
  always_comb step_fire = step_en && !mode_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      five_q <= 1'b0;
    end else if (mode_wr) begin
      idx_q  <= '0;
      five_q <= mode_sel;
    end else if (step_fire) begin
      idx_q  <= next_index(five_q, idx_q);
    end
  end

  assign cur_idx   = idx_q;
  assign five_mode = five_q;

  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (five_q ? (int'(idx_q) < LONG_LEN) : (int'(idx_q) < SHORT_LEN)));

  assert_modewr_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_wr) |-> (idx_q == '0) && (five_q == $past(mode_sel)));

endmodule

// File: rtl/fseq_decode.sv
module fseq_decode
  import fseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step_fire,
  input  step_idx_t cur_idx,
  input  logic      five_mode,
  output logic      qtr_q,
  output logic      half_q,
  output logic      irq_set
);

  always_comb irq_set = step_fire && step_raises_irq(five_mode, cur_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qtr_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      qtr_q  <= step_fire;
      half_q <= step_fire && step_half(cur_idx);
    end
  end

  assert_half_has_qtr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    half_q |-> qtr_q);

  assert_strobe_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    qtr_q |-> $past(step_fire));

endmodule

// File: rtl/fseq_irq.sv
module fseq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_set,
  input  logic irq_ack,
  input  logic irq_inhibit,
  output logic flag_q
);

  // inhibit beats set, set beats acknowledge
  always_ff @(posedge clk) begin
    if (!rst_n)           flag_q <= 1'b0;
    else if (irq_inhibit) flag_q <= 1'b0;
    else if (irq_set)     flag_q <= 1'b1;
    else if (irq_ack)     flag_q <= 1'b0;
  end

  assert_inhibit_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(irq_inhibit) |-> !flag_q);

  assert_set_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(irq_set));

  assert_flag_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !irq_ack && !irq_inhibit) |=> flag_q);

endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
  import fseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  input  logic mode_wr,
  input  logic mode_sel,
  input  logic irq_inhibit,
  input  logic irq_ack,
  output logic qtr_tick,
  output logic half_tick,
  output logic frame_irq
);

  step_idx_t cur_idx;
  logic      five_mode;
  logic      step_fire;
  logic      irq_set;

  fseq_stepper u_stepper (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .mode_wr   (mode_wr),
    .mode_sel  (mode_sel),
    .cur_idx   (cur_idx),
    .five_mode (five_mode),
    .step_fire (step_fire)
  );

  fseq_decode u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_fire (step_fire),
    .cur_idx   (cur_idx),
    .five_mode (five_mode),
    .qtr_q     (qtr_tick),
    .half_q    (half_tick),
    .irq_set   (irq_set)
  );

  fseq_irq u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_set     (irq_set),
    .irq_ack     (irq_ack),
    .irq_inhibit (irq_inhibit),
    .flag_q      (frame_irq)
  );

  assert_set_beats_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_set && irq_ack && !irq_inhibit) |=> frame_irq);

  assert_no_irq_five_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (five_mode && !irq_inhibit && !irq_ack && !frame_irq) |=> !frame_irq);

endmodule

// File: tb/frame_sequencer_test.sv
module frame_sequencer_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_en = 1'b0, mode_wr = 1'b0, mode_sel = 1'b0;
  logic irq_inhibit = 1'b0, irq_ack = 1'b0;
  logic qtr_tick, half_tick, frame_irq;

  always #10 clk = ~clk;   // 50 MHz

  frame_sequencer uut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .mode_wr(mode_wr),
    .mode_sel(mode_sel), .irq_inhibit(irq_inhibit), .irq_ack(irq_ack),
    .qtr_tick(qtr_tick), .half_tick(half_tick), .frame_irq(frame_irq)
  );

  // behavioural reference model
  int   m_idx = 0;
  bit   m_five = 1'b0;
  bit   e_q = 1'b0, e_h = 1'b0, e_i = 1'b0;
  bit   started = 1'b0;
  int   vectors = 0, fails = 0, cycles = 0;
  bit   done = 1'b0;
  string tag = "R1";

  always @(posedge clk) begin
    bit set_now;
    started <= 1'b1;
    cycles  <= cycles + 1;
    set_now = 1'b0;
    if (!rst_n) begin
      m_idx = 0; m_five = 1'b0; e_q = 1'b0; e_h = 1'b0; e_i = 1'b0;
    end else begin
      e_q = 1'b0; e_h = 1'b0;
      if (mode_wr) begin
        m_five = mode_sel;
        m_idx  = 0;
      end else if (step_en) begin
        e_q = 1'b1;
        e_h = (m_idx == 0) || (m_idx == 2);
        set_now = !m_five && (m_idx == 0);
        m_idx = (m_idx + 1) % (m_five ? 5 : 4);
      end
      if (irq_inhibit) e_i = 1'b0;
      else if (set_now) e_i = 1'b1;
      else if (irq_ack) e_i = 1'b0;
    end
  end

  task automatic chk(input string what, input logic act, input bit exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("qtr_tick", qtr_tick, e_q);
      chk("half_tick", half_tick, e_h);
      chk("frame_irq", frame_irq, e_i);
    end
  end

  task automatic drive(input logic se, input logic mw, input logic ms,
                       input logic inh, input logic ak);
    @(negedge clk);
    #1;
    step_en = se; mode_wr = mw; mode_sel = ms; irq_inhibit = inh; irq_ack = ak;
  endtask

  task automatic steps(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      for (int g = 0; g < gap; g++) drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cycles > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R2 / R3: four-step schedule with gaps, first step sets the flag
    tag = "R2";
    steps(9, 1);
    // R6: flag holds while idle, then acknowledge clears it
    tag = "R6";
    steps(0, 0);
    repeat (4) drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R7: inhibit over step 0 and clearing a set flag
    tag = "R7";
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);          // restart four-step
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);          // step 0 under inhibit
    steps(3, 0);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);          // step 0 sets
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);          // inhibit clears
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R4: five-step schedule, no interrupt
    tag = "R4";
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    steps(12, 1);
    // R8: mode write coinciding with a step drops it and restarts
    tag = "R8";
    steps(2, 0);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    steps(3, 0);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R9: set and acknowledge at the same edge
    tag = "R9";
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    steps(3, 0);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    // R5: back-to-back steps then idle
    tag = "R5";
    steps(10, 0);
    repeat (5) drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R3: random mix of all inputs
    tag = "R3";
    for (int k = 0; k < 3000; k++) begin
      drive(1'($urandom_range(0, 1)),
            1'($urandom_range(0, 19) == 0),
            1'($urandom_range(0, 1)),
            1'($urandom_range(0, 15) == 0),
            1'($urandom_range(0, 7) == 0));
    end
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    finish_run();
  end

endmodule